// File: doc/BRIEF.md
# Network Controller Command and Status Register

This block is the host-visible command and status word of a DMA network controller, plus three plain companion words. The host reaches all four through two ports. The select port picks one of the four words. The data port reads or writes the picked word. The main word (index 0) mixes several access kinds: event bits that a write of one clears, command bits that a write can set but never clear, and an interrupt-enable bit that a write loads directly. Error and interrupt summary bits are derived from the stored state on every cycle, and an interrupt request follows from them.

The transmit, receive and initialization engines are not part of this block. They appear only as single-cycle event pulses on the inputs. The block returns transmitter-on, receiver-on and command levels that those engines would act on. Host accesses are single-cycle strobes, and reads are combinational from the current state. No data path flows through the block, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status level.

Top module: `nic_ctrl_status`

## Requirements
- R1: After reset, word 0 reads 0x0004 (only the stop bit, bit 2, set), the select port reads 0, words 1 to 3 read 0, and irq is low.
- R2: Bits 14 (babble), 13 (collision error), 12 (missed packet), 11 (memory error), 10 (receive done), 9 (transmit done) and 8 (init done) clear when a 1 is written to them in word 0. Writing 0 leaves them alone. An event arriving in the same cycle as the clearing write keeps the bit set.
- R3: Bit 3 (transmit demand), bit 1 (start) and bit 0 (init) are set by writing 1 and are not cleared by writing 0. Setting start or init clears stop. A transmit-done pulse clears transmit demand.
- R4: Writing 1 to bit 2 (stop) sets stop and clears start and init, whatever else is in the same write.
- R5: Bit 6 (interrupt enable) takes the written value on every write to word 0.
- R6: Bit 15 reads as the OR of bits 14, 13, 12 and 11. Bit 7 reads as the OR of bits 14, 12, 11, 10, 9 and 8. Writes to bits 15 and 7 have no effect.
- R7: irq is high exactly when bit 7 and bit 6 are both high.
- R8: While the memory-error bit is set, bit 5 (receiver on) and bit 4 (transmitter on) are clear, even if an init-done pulse arrives.
- R9: While stop is set, the init-done bit reads 0.
- R10: An init-done pulse sets bit 8 and clears init. It also sets transmitter-on unless init_mode[1] is 1, and sets receiver-on unless init_mode[0] is 1.
- R11: A select write keeps only the low 2 bits of the data, and the select port reads back that value.
- R12: Words 1 to 3 store and return any 16-bit value written through the data port, without touching word 0.
- R13: The event inputs set their bits: ev_babble bit 14, ev_coll_err bit 13, ev_missed bit 12, ev_mem_err bit 11, ev_rx_done bit 10, ev_tx_done bit 9, ev_init_done bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_port | input | 1 | 0 = data port, 1 = select port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read value of the addressed port |
| ev_babble | input | 1 | Babble event pulse |
| ev_coll_err | input | 1 | Collision error event pulse |
| ev_missed | input | 1 | Missed packet event pulse |
| ev_mem_err | input | 1 | Memory error event pulse |
| ev_rx_done | input | 1 | Receive completion pulse |
| ev_tx_done | input | 1 | Transmit completion pulse |
| ev_init_done | input | 1 | Initialization completion pulse |
| init_mode | input | 2 | Mode word bits: [1] disable transmit, [0] disable receive |
| irq | output | 1 | Interrupt request |
| tx_on | output | 1 | Transmitter enabled |
| rx_on | output | 1 | Receiver enabled |
| start_cmd | output | 1 | Start command level |
| init_cmd | output | 1 | Init command level |
| tx_demand | output | 1 | Transmit demand level |
| stopped | output | 1 | Stop level |

## Verification
The assertions assume that host_wr is a strobe that addresses only one port per cycle. They also assume that event pulses are sampled at the same edges as host writes, and that init_mode is stable whenever ev_init_done is high. The bench drives every input on the falling edge and holds each pulse for exactly one cycle. It changes init_mode only between pulses, so these assumptions always hold. Same-cycle overlaps of a clearing write with an event, and of a stop write with start and init, are produced on purpose so that the priority rules are exercised.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

  localparam int CSR_W = 16;

  localparam int B_ERR  = 15;
  localparam int B_BABL = 14;
  localparam int B_CERR = 13;
  localparam int B_MISS = 12;
  localparam int B_MERR = 11;
  localparam int B_RINT = 10;
  localparam int B_TINT = 9;
  localparam int B_IDON = 8;
  localparam int B_INTR = 7;
  localparam int B_INEA = 6;
  localparam int B_RXON = 5;
  localparam int B_TXON = 4;
  localparam int B_TDMD = 3;
  localparam int B_STOP = 2;
  localparam int B_STRT = 1;
  localparam int B_INIT = 0;

  typedef struct packed {
    logic babl;
    logic cerr;
    logic miss;
    logic merr;
    logic rint;
    logic tint;
    logic idon;
    logic inea;
    logic rxon;
    logic txon;
    logic tdmd;
    logic stop;
    logic strt;
    logic init;
  } csr_state_t;

  typedef struct packed {
    logic babble;
    logic coll;
    logic missed;
    logic mem;
    logic rx_done;
    logic tx_done;
    logic init_done;
  } csr_events_t;

  localparam csr_state_t CSR_RESET = '{stop: 1'b1, default: 1'b0};

endpackage

// File: rtl/csr_status_core.sv
module csr_status_core
  import nic_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CSR_W-1:0]  wdata,
  input  csr_events_t       ev,
  input  logic              dis_tx,
  input  logic              dis_rx,
  output csr_state_t        st
);

  csr_state_t nx;
  logic [CSR_W-1:0] clr;
  logic unused_summary_bits;

  assign unused_summary_bits = ^{wdata[B_ERR], wdata[B_INTR]};
  assign clr = wr_en ? wdata : '0;

  always_comb begin
    nx = st;
    // write-one-to-clear, event wins
    nx.babl = (st.babl & ~clr[B_BABL]) | ev.babble;
    nx.cerr = (st.cerr & ~clr[B_CERR]) | ev.coll;
    nx.miss = (st.miss & ~clr[B_MISS]) | ev.missed;
    nx.merr = (st.merr & ~clr[B_MERR]) | ev.mem;
    nx.rint = (st.rint & ~clr[B_RINT]) | ev.rx_done;
    nx.tint = (st.tint & ~clr[B_TINT]) | ev.tx_done;
    nx.idon = (st.idon & ~clr[B_IDON]) | ev.init_done;
    if (ev.tx_done) nx.tdmd = 1'b0;
    if (ev.init_done) begin
      nx.init = 1'b0;
      nx.txon = ~dis_tx;
      nx.rxon = ~dis_rx;
    end
    if (wr_en) begin
      if (wdata[B_TDMD]) nx.tdmd = 1'b1;
      if (wdata[B_STRT]) begin
        nx.strt = 1'b1;
        nx.stop = 1'b0;
      end
      if (wdata[B_INIT]) begin
        nx.init = 1'b1;
        nx.stop = 1'b0;
      end
      if (wdata[B_STOP]) begin
        nx.stop = 1'b1;
        nx.strt = 1'b0;
        nx.init = 1'b0;
      end
      nx.inea = wdata[B_INEA];
    end
    if (nx.merr) begin
      nx.rxon = 1'b0;
      nx.txon = 1'b0;
    end
    if (nx.stop) nx.idon = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= CSR_RESET;
    else        st <= nx;
  end

  // R4
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[B_STOP]) |=> (st.stop && !st.strt && !st.init));

  // R8
  merr_kills_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.merr |-> (!st.rxon && !st.txon));

  // R9
  stop_hides_idon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.stop |-> !st.idon);

  // R10
  init_done_clears_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.init_done && !(wr_en && wdata[B_INIT])) |=> !st.init);

endmodule

// File: rtl/csr_summary.sv
module csr_summary
  import nic_csr_pkg::*;
(
  input  csr_state_t        st,
  output logic              err,
  output logic              intr,
  output logic              irq,
  output logic [CSR_W-1:0]  word
);

  assign err  = st.babl | st.cerr | st.miss | st.merr;
  assign intr = st.babl | st.miss | st.merr | st.rint | st.tint | st.idon;
  assign irq  = intr & st.inea;

  always_comb begin
    word         = '0;
    word[B_ERR]  = err;
    word[B_BABL] = st.babl;
    word[B_CERR] = st.cerr;
    word[B_MISS] = st.miss;
    word[B_MERR] = st.merr;
    word[B_RINT] = st.rint;
    word[B_TINT] = st.tint;
    word[B_IDON] = st.idon;
    word[B_INTR] = intr;
    word[B_INEA] = st.inea;
    word[B_RXON] = st.rxon;
    word[B_TXON] = st.txon;
    word[B_TDMD] = st.tdmd;
    word[B_STOP] = st.stop;
    word[B_STRT] = st.strt;
    word[B_INIT] = st.init;
  end

endmodule

// File: rtl/csr_aux_regs.sv
module csr_aux_regs #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic [SEL_W-1:0]  sel_wdata,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] rd_aux
);

  logic [DATA_W-1:0] bank [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel <= '0;
    else if (sel_wr) sel <= sel_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_REGS; k++) bank[k] <= '0;
    end else begin
      for (int k = 1; k < NUM_REGS; k++)
        if (data_wr && sel == SEL_W'(k)) bank[k] <= wdata;
    end
  end

  assign rd_aux = bank[sel];

  // R11
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (sel == $past(sel_wdata)));

  // R12
  aux_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && sel != '0) |=> (bank[$past(sel)] == $past(wdata)));

endmodule

// File: rtl/nic_ctrl_status.sv
module nic_ctrl_status
  import nic_csr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_port,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              ev_babble,
  input  logic              ev_coll_err,
  input  logic              ev_missed,
  input  logic              ev_mem_err,
  input  logic              ev_rx_done,
  input  logic              ev_tx_done,
  input  logic              ev_init_done,
  input  logic [1:0]        init_mode,
  output logic              irq,
  output logic              tx_on,
  output logic              rx_on,
  output logic              start_cmd,
  output logic              init_cmd,
  output logic              tx_demand,
  output logic              stopped
);

  csr_state_t        st;
  csr_events_t       ev;
  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] rd_aux;
  logic [CSR_W-1:0]  csr_word;
  logic              err, intr;
  logic              sel_wr, data_wr, csr_wr;

  assign sel_wr  = host_wr &  host_port;
  assign data_wr = host_wr & ~host_port;
  assign csr_wr  = data_wr & (sel == '0);

  assign ev = '{babble: ev_babble, coll: ev_coll_err, missed: ev_missed,
                mem: ev_mem_err, rx_done: ev_rx_done, tx_done: ev_tx_done,
                init_done: ev_init_done};

  csr_status_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (csr_wr),
    .wdata  (host_wdata[CSR_W-1:0]),
    .ev     (ev),
    .dis_tx (init_mode[1]),
    .dis_rx (init_mode[0]),
    .st     (st)
  );

  csr_summary u_sum (
    .st   (st),
    .err  (err),
    .intr (intr),
    .irq  (irq),
    .word (csr_word)
  );

  csr_aux_regs #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_aux (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_wr    (sel_wr),
    .sel_wdata (host_wdata[SEL_W-1:0]),
    .data_wr   (data_wr),
    .wdata     (host_wdata),
    .sel       (sel),
    .rd_aux    (rd_aux)
  );

  always_comb begin
    if (host_port)        host_rdata = DATA_W'(sel);
    else if (sel == '0)   host_rdata = DATA_W'(csr_word);
    else                  host_rdata = rd_aux;
  end

  assign tx_on     = st.txon;
  assign rx_on     = st.rxon;
  assign start_cmd = st.strt;
  assign init_cmd  = st.init;
  assign tx_demand = st.tdmd;
  assign stopped   = st.stop;

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st.inea && intr));

  // R6
  err_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.cerr |-> err);

endmodule

// File: tb/sim_nic_ctrl_status.sv
`timescale 1ns/1ps
module sim_nic_ctrl_status;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_port = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [6:0]  evs = '0;
  logic [1:0]  init_mode = 2'b00;
  logic        irq, tx_on, rx_on, start_cmd, init_cmd, tx_demand, stopped;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // evs: [6] babble [5] coll [4] missed [3] mem [2] rx [1] tx [0] init_done
  nic_ctrl_status u0 (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_port(host_port),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ev_babble(evs[6]), .ev_coll_err(evs[5]), .ev_missed(evs[4]),
    .ev_mem_err(evs[3]), .ev_rx_done(evs[2]), .ev_tx_done(evs[1]),
    .ev_init_done(evs[0]), .init_mode(init_mode),
    .irq(irq), .tx_on(tx_on), .rx_on(rx_on), .start_cmd(start_cmd),
    .init_cmd(init_cmd), .tx_demand(tx_demand), .stopped(stopped)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic port, input logic [15:0] d);
    host_wr = 1'b1; host_port = port; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_port = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] m);
    evs = m;
    @(negedge clk);
    evs = '0;
  endtask

  task automatic rd(input logic port, output logic [15:0] v);
    host_port = port;
    #1 v = host_rdata;
    host_port = 1'b0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      report();
    end
  end

  initial begin
    logic [15:0] v, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 word0", v, 16'h0004);
    rd(1, v); chk("R1 select", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    for (int k = 1; k < 4; k++) begin
      wr(1, 16'(k)); rd(0, v); chk("R1 companion", v, 16'h0000);
    end
    wr(1, 16'h0000);

    // R4 stop beats start and init
    wr(0, 16'h0007); rd(0, v); chk("R4 stop+strt+init", v, 16'h0004);

    // R3 set-only commands
    wr(0, 16'h0002); rd(0, v); chk("R3 start clears stop", v, 16'h0002);
    wr(0, 16'h0000); rd(0, v); chk("R3 start not clearable", v, 16'h0002);
    wr(0, 16'h0008); rd(0, v); chk("R3 demand set", v, 16'h000A);
    wr(0, 16'h0000); rd(0, v); chk("R3 demand not clearable", v, 16'h000A);
    pulse(7'b0000010); rd(0, v); chk("R3 tx done clears demand", v, 16'h0282);
    wr(0, 16'h0200); rd(0, v); chk("R2 tint cleared", v, 16'h0002);
    wr(0, 16'h0004); rd(0, v); chk("R4 stop clears start", v, 16'h0004);
    wr(0, 16'h0001); rd(0, v); chk("R3 init clears stop", v, 16'h0001);

    // R10 init done under each mode
    for (int m = 0; m < 4; m++) begin
      wr(0, 16'h0101);
      init_mode = 2'(m);
      pulse(7'b0000001);
      rd(0, v);
      e = 16'h0180 | (m[1] ? 16'h0 : 16'h0010) | (m[0] ? 16'h0 : 16'h0020);
      chk("R10 init done word", v, e);
      chk("R10 enables", {14'd0, tx_on, rx_on}, {14'd0, ~m[1], ~m[0]});
      chk("R10 init cmd", {15'd0, init_cmd}, 16'h0000);
    end
    init_mode = 2'b00;

    // R8 memory error forces enables off
    pulse(7'b0000001);
    chk("R8 enabled before", {14'd0, tx_on, rx_on}, 16'h0003);
    pulse(7'b0001000);
    chk("R8 mem error off", {14'd0, tx_on, rx_on}, 16'h0000);
    pulse(7'b0000001);
    chk("R8 init done blocked", {14'd0, tx_on, rx_on}, 16'h0000);
    wr(0, 16'h0800);
    chk("R8 stays off after clear", {14'd0, tx_on, rx_on}, 16'h0000);
    pulse(7'b0000001);
    chk("R8 re-enabled by init done", {14'd0, tx_on, rx_on}, 16'h0003);

    // R9 stop hides init done
    wr(0, 16'h0004); rd(0, v); chk("R9 idon cleared by stop", v & 16'h0100, 16'h0000);
    pulse(7'b0000001); rd(0, v); chk("R9 idon held low", v & 16'h0100, 16'h0000);

    // R2 event beats same-cycle clear
    wr(0, 16'h0002);
    evs = 7'b1000000; host_wr = 1'b1; host_wdata = 16'h4000;
    @(negedge clk);
    evs = '0; host_wr = 1'b0;
    rd(0, v); chk("R2 event wins", v & 16'h4000, 16'h4000);
    wr(0, 16'h4000); rd(0, v); chk("R2 babble cleared", v & 16'h4000, 16'h0000);

    // R5 R6 R7 R13 sweep of all event sets and enable
    for (int ie = 0; ie < 2; ie++) begin
      for (int c = 0; c < 128; c++) begin
        logic er, it;
        wr(0, 16'h7F02 | (ie[0] ? 16'h0040 : 16'h0000));
        pulse(7'(c));
        rd(0, v);
        er = c[6] | c[5] | c[4] | c[3];
        it = c[6] | c[4] | c[3] | c[2] | c[1] | (c[0] & 1'b1);
        e = {er, c[6], c[5], c[4], c[3], c[2], c[1], c[0], it, ie[0], 6'b000010};
        chk("R13 R6 R5 word", v & 16'hFFCF, e);
        chk("R7 irq", {15'd0, irq}, {15'd0, it & ie[0]});
      end
    end
    wr(0, 16'h7F02);
    wr(0, 16'h8082); rd(0, v); chk("R6 summary bits not writable", v, 16'h0002);

    // R11 select masking
    for (int s = 0; s < 16; s++) begin
      wr(1, 16'(s)); rd(1, v); chk("R11 select", v, 16'(s & 3));
    end

    // R12 companion words
    for (int k = 1; k < 4; k++) begin
      wr(1, 16'(k)); wr(0, 16'hA5C3 ^ 16'(k * 16'h1357));
    end
    for (int k = 1; k < 4; k++) begin
      wr(1, 16'(k)); rd(0, v); chk("R12 companion", v, 16'hA5C3 ^ 16'(k * 16'h1357));
    end
    wr(1, 16'h0000); rd(0, v); chk("R12 word0 untouched", v, 16'h0002);

    done = 1'b1;
    report();
  end

endmodule